// File: doc/BRIEF.md
# Bus Initiator Address Sequencer

This block is the initiator side of a cycle-synchronous, multiplexed address/data bus. A caller hands it one request: a 64-bit address, a 4-bit command, a direction, a burst length and, beat by beat, a 32-bit write word and a 4-bit byte-lane mask. The block raises a request to an external arbiter. Once the grant arrives it drives the address phase and then the data phases. At the end it reports how many data phases the target actually accepted.

The address phase takes one cycle when the upper 32 address bits are all zero. Otherwise it takes two cycles: the low word goes out with the dual-address command `4'b1101`, and the high word follows with the real command. During data phases the target paces the transfer with a ready input and may cut the burst short with a stop input. Because the completion count is reported, a caller can reissue the rest of a truncated burst. Every transaction ends with one idle bus cycle, during which the completion pulse is given.

The state machine has six states:
- `ST_IDLE`: ready for a request. It goes to `ST_ARB` when a request is accepted.
- `ST_ARB`: requesting the bus. It goes to `ST_ADR1` when the grant is seen.
- `ST_ADR1`: first address cycle. It goes to `ST_ADR2` if the address needs two cycles, otherwise to `ST_DATA`.
- `ST_ADR2`: second address cycle. It always goes to `ST_DATA`.
- `ST_DATA`: data phases. It goes to `ST_TURN` on the last accepted beat or on a stop.
- `ST_TURN`: idle bus cycle with the completion pulse. It always goes to `ST_IDLE`.

Top module: `bus_init_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `bus_req`, `frame`, `irdy`, `ad_oe` and `done` are all 0.
- R2: When `req_valid` is seen while `req_ready` is 1, the request is accepted. `bus_req` is then held high, and `frame` stays low, until `bus_gnt` is sampled high. The first address cycle is driven in the following cycle.
- R3: If `req_addr[63:32]` is zero, the address phase is one cycle, with `ad_out = req_addr[31:0]` and `cbe_out = req_cmd`. In that case the code `4'b1101` is never used.
- R4: If `req_addr[63:32]` is nonzero, the address phase is two cycles. The first carries `req_addr[31:0]` with `cbe_out = 4'b1101`. The second carries `req_addr[63:32]` with `cbe_out = req_cmd`.
- R5: Data phases start in the cycle right after the last address cycle, with `irdy` high. During beat i (counted from 0) the outputs are `beat_idx = i` and `cbe_out = beat_be`. On a write (`req_write = 1`) they are also `ad_out = beat_data` and `ad_oe = 1`.
- R6: On a read, `ad_oe` is 0 in data phases. `rd_valid` is 1 with `rd_data = ad_in` in each cycle where the target signals ready.
- R7: While `trdy` and `stop` are both low in a data phase, the beat is held: `irdy` stays high and `beat_idx` is unchanged.
- R8: A burst ends after `req_len` accepted beats (1 to `MAX_BEATS`). A length of 0 is treated as 1.
- R9: If `stop` is high together with `trdy`, the beat counts and no further beat follows. If `stop` is high without `trdy`, the transaction ends and that beat is not counted.
- R10: `done` pulses for one cycle in an idle bus cycle (`frame`, `irdy` and `ad_oe` all low), with `done_count` equal to the number of beats accepted. `req_ready` returns in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_addr | input | 64 | Transaction address |
| req_cmd | input | 4 | Command code for the transaction |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | LEN_W (5) | Number of data beats |
| beat_idx | output | IDX_W (4) | Index of the current beat |
| beat_data | input | 32 | Write word for the current beat |
| beat_be | input | 4 | Byte-lane mask for the current beat |
| bus_req | output | 1 | Request to the arbiter |
| bus_gnt | input | 1 | Grant from the arbiter |
| frame | output | 1 | Transaction in progress |
| irdy | output | 1 | Initiator ready in a data phase |
| ad_out | output | 32 | Multiplexed address/data out |
| ad_oe | output | 1 | Drive enable for ad_out |
| cbe_out | output | 4 | Command or byte-lane mask |
| ad_in | input | 32 | Multiplexed data from the target |
| trdy | input | 1 | Target ready |
| stop | input | 1 | Target ends the transaction |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 32 | Read word |
| done | output | 1 | Transaction complete pulse |
| done_count | output | LEN_W (5) | Beats accepted in the finished transaction |

## Verification
A wrong state appears on the bus within one cycle. An unexpected dual-address code, a missing or extra address word, or an address cycle before the grant shows up as a mismatch on `ad_out` and `cbe_out` in the cycle it is driven. A beat counter that is off shows up as wrong write data or byte masks on the next accepted beat, and in `done_count`. A missed stop or length end shows up as one extra beat with `irdy` high in the cycle after the last accepted beat. A sequence-ordered scoreboard compares every address cycle, data beat and completion against these expectations.

// File: rtl/bis_pkg.sv
package bis_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_ADR1,
        ST_ADR2,
        ST_DATA,
        ST_TURN
    } seq_state_t;

    localparam logic [3:0] CMD_DUAL_ADDR = 4'b1101;
    localparam logic [3:0] CMD_MEM_RD    = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR    = 4'b0111;
endpackage

// File: rtl/bis_addr_sel.sv
module bis_addr_sel
    import bis_pkg::*;
(
    input  logic [63:0] addr,
    input  logic [3:0]  cmd,
    output logic        two_cycle,
    output logic [31:0] first_word,
    output logic [3:0]  first_code,
    output logic [31:0] second_word,
    output logic [3:0]  second_code
);
    always_comb begin
        two_cycle   = |addr[63:32];
        first_word  = addr[31:0];
        first_code  = two_cycle ? CMD_DUAL_ADDR : cmd;
        second_word = addr[63:32];
        second_code = cmd;
    end
endmodule

// File: rtl/bis_beat_cnt.sv
module bis_beat_cnt #(
    parameter int MAX_BEATS = 16,
    localparam int LEN_W = $clog2(MAX_BEATS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] count,
    output logic             last
);
    logic [LEN_W-1:0] len_eff;

    always_comb begin
        len_eff = (len == '0) ? LEN_W'(1) : len;
        last    = (count == len_eff - LEN_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) count <= '0;
        else if (inc)        count <= count + LEN_W'(1);
    end

    // R8: a beat is never accepted beyond the requested length
    a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (count < len_eff));
endmodule

// File: rtl/bus_init_seq.sv
module bus_init_seq
    import bis_pkg::*;
#(
    parameter int MAX_BEATS = 16,
    localparam int LEN_W = $clog2(MAX_BEATS + 1),
    localparam int IDX_W = $clog2(MAX_BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [63:0]      req_addr,
    input  logic [3:0]       req_cmd,
    input  logic             req_write,
    input  logic [LEN_W-1:0] req_len,
    output logic [IDX_W-1:0] beat_idx,
    input  logic [31:0]      beat_data,
    input  logic [3:0]       beat_be,
    output logic             bus_req,
    input  logic             bus_gnt,
    output logic             frame,
    output logic             irdy,
    output logic [31:0]      ad_out,
    output logic             ad_oe,
    output logic [3:0]       cbe_out,
    input  logic [31:0]      ad_in,
    input  logic             trdy,
    input  logic             stop,
    output logic             rd_valid,
    output logic [31:0]      rd_data,
    output logic             done,
    output logic [LEN_W-1:0] done_count
);
    seq_state_t state, nxt;

    logic [63:0]      addr_q;
    logic [3:0]       cmd_q;
    logic             wr_q;
    logic [LEN_W-1:0] len_q;

    logic             two_cycle;
    logic [31:0]      w1, w2;
    logic [3:0]       c1, c2;
    logic [LEN_W-1:0] cnt;
    logic             last_beat;
    logic             accept;

    assign accept = (state == ST_IDLE) && req_valid;

    bis_addr_sel u_sel (
        .addr(addr_q), .cmd(cmd_q), .two_cycle(two_cycle),
        .first_word(w1), .first_code(c1),
        .second_word(w2), .second_code(c2)
    );

    bis_beat_cnt #(.MAX_BEATS(MAX_BEATS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(accept),
        .inc((state == ST_DATA) && trdy),
        .len(len_q), .count(cnt), .last(last_beat)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cmd_q  <= '0;
            wr_q   <= 1'b0;
            len_q  <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            cmd_q  <= req_cmd;
            wr_q   <= req_write;
            len_q  <= req_len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req_valid) nxt = ST_ARB;
            ST_ARB:  if (bus_gnt)   nxt = ST_ADR1;
            ST_ADR1: nxt = two_cycle ? ST_ADR2 : ST_DATA;
            ST_ADR2: nxt = ST_DATA;
            ST_DATA: if (stop || (trdy && last_beat)) nxt = ST_TURN;
            ST_TURN: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready  = 1'b0;
        bus_req    = 1'b0;
        frame      = 1'b0;
        irdy       = 1'b0;
        ad_out     = '0;
        ad_oe      = 1'b0;
        cbe_out    = '0;
        rd_valid   = 1'b0;
        rd_data    = ad_in;
        done       = 1'b0;
        done_count = cnt;
        beat_idx   = cnt[IDX_W-1:0];
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_ARB:  bus_req = 1'b1;
            ST_ADR1: begin
                frame   = 1'b1;
                ad_oe   = 1'b1;
                ad_out  = w1;
                cbe_out = c1;
            end
            ST_ADR2: begin
                frame   = 1'b1;
                ad_oe   = 1'b1;
                ad_out  = w2;
                cbe_out = c2;
            end
            ST_DATA: begin
                frame    = !last_beat;
                irdy     = 1'b1;
                cbe_out  = beat_be;
                ad_oe    = wr_q;
                ad_out   = wr_q ? beat_data : '0;
                rd_valid = !wr_q && trdy;
            end
            ST_TURN: done = 1'b1;
            default: ;
        endcase
    end

    // R2: an address cycle only starts after the arbiter grant
    a_r2_addr_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADR1) |-> $past(bus_gnt && bus_req));
    // R3: the dual-address code never appears when the high word is zero
    a_r3_no_needless_dual: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ADR1) && (addr_q[63:32] == '0)) |-> (cbe_out != CMD_DUAL_ADDR));
    // R7: a beat waiting on the target is held
    a_r7_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irdy && !trdy && !stop) |=> (irdy && $stable(beat_idx)));
    // R9: a stop ends the data phases
    a_r9_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (irdy && stop) |=> !irdy);
    // R10: completion is reported on a quiet bus
    a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!frame && !irdy && !ad_oe && !bus_req));
endmodule

// File: tb/sim_bus_init_seq.sv
module sim_bus_init_seq;
    localparam int MAXB = 16;
    localparam int LW = $clog2(MAXB + 1);
    localparam int IW = $clog2(MAXB);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [63:0]   req_addr = '0;
    logic [3:0]    req_cmd = '0;
    logic [LW-1:0] req_len = '0;
    logic [IW-1:0] beat_idx;
    logic [31:0]   beat_data;
    logic [3:0]    beat_be;
    logic          bus_req, bus_gnt = 1'b0, frame, irdy, ad_oe;
    logic [31:0]   ad_out, ad_in = '0, rd_data;
    logic [3:0]    cbe_out;
    logic          trdy = 1'b0, stop = 1'b0, rd_valid, done;
    logic [LW-1:0] done_count;

    assign beat_data = 32'hA000_0000 | {28'd0, beat_idx};
    assign beat_be   = 4'hF ^ beat_idx;

    bus_init_seq #(.MAX_BEATS(MAXB)) u0 (.*);

    typedef struct {
        int          kind; // 0 address, 1 data, 2 done
        logic [31:0] ad;
        logic [3:0]  cbe;
        logic        wr;
    } exp_t;
    exp_t q[$];

    int total = 0, bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            exp_t e;
            if (frame && !irdy) begin
                if (q.size() == 0 || q[0].kind != 0) chk(1'b0, "R3/R4 unexpected address cycle", {32'd0, ad_out}, 0);
                else begin
                    e = q.pop_front();
                    chk(ad_out == e.ad && ad_oe, "R3/R4 address word", {32'd0, ad_out}, {32'd0, e.ad});
                    chk(cbe_out == e.cbe, "R3/R4 address command", {60'd0, cbe_out}, {60'd0, e.cbe});
                end
            end
            if (irdy && trdy) begin
                if (q.size() == 0 || q[0].kind != 1) chk(1'b0, "R8/R9 unexpected beat", {60'd0, beat_idx}, 0);
                else begin
                    e = q.pop_front();
                    chk(cbe_out == e.cbe, "R5 byte mask", {60'd0, cbe_out}, {60'd0, e.cbe});
                    if (e.wr) chk(ad_out == e.ad && ad_oe, "R5 write data", {31'd0, ad_oe, ad_out}, {31'd1, e.ad});
                    else chk(rd_data == e.ad && rd_valid && !ad_oe, "R6 read data", {30'd0, rd_valid, ad_oe, rd_data}, {30'd2, e.ad});
                end
            end
            if (done) begin
                if (q.size() == 0 || q[0].kind != 2) chk(1'b0, "R10 unexpected done", 0, 0);
                else begin
                    e = q.pop_front();
                    chk(done_count == e.ad[LW-1:0], "R10 done count", {59'd0, done_count}, {32'd0, e.ad});
                    chk(!frame && !irdy && !ad_oe, "R10 idle at done", {61'd0, frame, irdy, ad_oe}, 0);
                end
            end
        end
    end

    task automatic run_tx(input logic [63:0] a, input bit wr, input int len, input int waits,
                          input int stop_at, input bit stop_data, input int gnt_delay);
        logic [3:0] cmd;
        int eff, n, beats, w;
        bit hs;
        exp_t e;
        cmd = wr ? 4'b0111 : 4'b0110;
        eff = (len == 0) ? 1 : len;
        n = eff;
        if (stop_at > 0 && stop_at <= eff) n = stop_data ? stop_at : stop_at - 1;
        if (a[63:32] != 0) begin
            e = '{0, a[31:0], 4'b1101, wr}; q.push_back(e);
            e = '{0, a[63:32], cmd, wr};    q.push_back(e);
        end else begin
            e = '{0, a[31:0], cmd, wr};     q.push_back(e);
        end
        for (int i = 0; i < n; i++) begin
            e = '{1, wr ? (32'hA000_0000 + i) : (32'h5000_0000 + i), 4'hF ^ 4'(i), wr};
            q.push_back(e);
        end
        e = '{2, 32'(n), 4'h0, wr}; q.push_back(e);

        @(posedge clk); #2;
        req_valid = 1'b1; req_addr = a; req_cmd = cmd; req_write = wr; req_len = LW'(len);
        @(posedge clk); #2;
        req_valid = 1'b0;
        for (int g = 0; g < gnt_delay; g++) begin
            chk(bus_req && !frame, "R2 request held before grant", {62'd0, bus_req, frame}, 64'd2);
            @(posedge clk); #2;
        end
        bus_gnt = 1'b1;
        @(posedge clk); #2;
        bus_gnt = 1'b0;
        beats = 0; w = 0;
        for (int c = 0; c < 200; c++) begin
            trdy = 1'b0; stop = 1'b0;
            if (irdy) begin
                if (w < waits) w++;
                else begin
                    ad_in = 32'h5000_0000 + beats;
                    if (stop_at == beats + 1 && !stop_data) stop = 1'b1;
                    else begin
                        trdy = 1'b1;
                        stop = (stop_at == beats + 1);
                    end
                end
            end
            hs = irdy && trdy;
            @(posedge clk); #2;
            if (hs) begin beats++; w = 0; end
            if (done) break;
        end
        trdy = 1'b0; stop = 1'b0;
        @(posedge clk); #2;
        chk(req_ready, "R10 ready after done", {63'd0, req_ready}, 64'd1);
    endtask

    initial begin
        #(20 * 100000);
        chk(1'b0, "watchdog", 0, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !bus_req && !frame && !irdy && !ad_oe && !done, "R1 reset state",
            {58'd0, req_ready, bus_req, frame, irdy, ad_oe, done}, 64'h20);
        run_tx(64'h0000_0000_1234_5670, 1'b1, 4, 0, 0, 1'b0, 2);   // R3 R5 R8 single address write
        run_tx(64'h0000_0001_8000_0000, 1'b0, 3, 1, 0, 1'b0, 0);   // R4 R6 R7 dual address read with waits
        run_tx(64'h0000_00FF_0000_0040, 1'b1, 6, 0, 2, 1'b1, 1);   // R9 stop with data
        run_tx(64'h0000_0000_0000_0100, 1'b0, 5, 0, 1, 1'b0, 0);   // R9 stop without data
        run_tx(64'h0000_0000_0000_0200, 1'b1, 0, 0, 0, 1'b0, 0);   // R8 length zero as one
        run_tx(64'h0000_0000_FFFF_FFF0, 1'b0, 2, 0, 0, 1'b0, 3);   // R3 high low word, single cycle
        run_tx(64'hFFFF_FFFF_0000_1000, 1'b1, 16, 2, 0, 1'b0, 1);  // R7 R8 full burst with waits
        run_tx(64'h0000_0000_0000_0300, 1'b0, 8, 1, 5, 1'b0, 0);   // R9 disconnect mid-burst
        repeat (2) @(posedge clk);
        chk(q.size() == 0, "R8 scoreboard drained", 64'(q.size()), 0);
        finish_run();
    end
endmodule